// File: doc/BRIEF.md
# Counted Beam Permit Gate

This block decides when beam may be delivered during a profile-monitor acquisition. A controller chooses either a burst of a set number of beam pulses or a single shot. It then raises a request line. The block opens its permit window only on a timing strobe from the event receiver. It counts the strobes that arrive while the window is open and closes the window once the requested number of pulses has been delivered. Every sequence starts and ends with a period in which the permit is low.

The gate only says when beam is allowed. The maximum repetition rate stays with a separate rate limiter, which combines `permit` with its own limits. Single-shot mode uses a set/clear latch in place of a counter. The latch is set when the shot is requested and cleared by the strobe of the pulse it allows, so a second pulse cannot follow. All outputs are registered. "The next cycle" below means the clock edge after the one at which the inputs are sampled.

Top module: `beam_gate`

## Requirements
- R1: While reset is applied, and on the first cycle after it, `permit` and `done` are both 0.
- R2: A rising edge on `req` with `burst_en`=1 and `shot_en`=0 arms a burst. `permit` stays 0 until the first `tick` after arming and goes to 1 on the cycle after that tick.
- R3: In burst mode with a captured count N≥1, `permit` stays 1 through the first N ticks seen while it is high, counting the one that opened it. It falls on the cycle after the (N+1)-th tick since arming, so exactly N strobes fall inside the window.
- R4: When `permit` falls at the normal end of a sequence, `done` goes to 1 on the same cycle. `permit` then stays 0 and `done` stays 1 for as long as `req` is held, whatever the ticks do. `done` returns to 0 on the cycle after `req` goes low. A new sequence needs a new rising edge on `req`.
- R5: A burst request with `count`=0 never raises `permit` and sets `done` on the cycle after the rising edge of `req`.
- R6: `count` is sampled only at the rising edge of `req`. Changing it during a sequence does not change the number of strobes in the window.
- R7: In single-shot mode (`shot_en`=1 at the rising edge of `req`), `permit` opens on the first tick and closes on the next one, whatever the value of `count`. Further ticks leave it at 0.
- R8: When `shot_en` and `burst_en` are both 1 at the rising edge of `req`, the block runs a single shot.
- R9: Outside an abort, `permit` changes only on the cycle after a `tick`.
- R10: While a sequence is armed or open, if `req` goes low or the enable of the active mode goes low, `permit` is 0 on the next cycle and `done` stays 0. Restoring the enable without a new `req` edge does not reopen the window.
- R11: A rising edge on `req` while both mode enables are 0 is ignored. `permit` and `done` stay 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | One-cycle timing strobe, one per beam pulse slot |
| burst_en | input | 1 | Enables burst mode |
| shot_en | input | 1 | Enables single-shot mode (takes priority) |
| req | input | 1 | Request to allow beam; the rising edge starts a sequence |
| count | input | CNT_W | Number of pulses in a burst, sampled at the rising edge of `req` |
| permit | output | 1 | Beam allowed |
| done | output | 1 | Sequence finished; held until `req` goes low |

## Verification
A wrong count or a wrong latch state shows up as the permit window closing one strobe early or late. The bench therefore samples `permit` after every individual tick rather than only at the end of a sequence. A state machine that fails to leave its finished state, or leaves it too early, shows up within one cycle as `done` being wrong around the fall of `req`. A missed abort leaves `permit` high one cycle after an enable or the request drops, and the bench checks exactly that cycle.

// File: rtl/beam_gate_pkg.sv
package beam_gate_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_ARM  = 2'd1,
        ST_RUN  = 2'd2,
        ST_DONE = 2'd3
    } gate_state_e;

    typedef struct packed {
        gate_state_e state;
        logic        permit;
        logic        done;
        logic        shot;
        logic        req_seen;
    } gate_regs_t;

    localparam gate_regs_t GATE_RESET = '{
        state:    ST_IDLE,
        permit:   1'b0,
        done:     1'b0,
        shot:     1'b0,
        req_seen: 1'b0
    };

endpackage

// File: rtl/beam_gate_cnt.sv
module beam_gate_cnt #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             dec,
    output logic             last
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load) begin
            cnt_d = load_val;
        end else if (dec) begin
            cnt_d = cnt_q - ONE;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign last = (cnt_q == ONE);

    AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        dec |-> (cnt_q > ONE)) else $error("counter decremented at or below one"); // R3

    AST_LOAD_DEC_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(load && dec)) else $error("load and decrement together"); // R6

endmodule

// File: rtl/beam_gate_latch.sv
module beam_gate_latch (
    input  logic clk,
    input  logic rst_n,
    input  logic set,
    input  logic clr,
    output logic q
);
    logic q_d, q_q;

    always_comb begin
        q_d = q_q;
        if (clr) begin
            q_d = 1'b0;
        end else if (set) begin
            q_d = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q_q <= 1'b0;
        end else begin
            q_q <= q_d;
        end
    end

    assign q = q_q;

    AST_SET_CLR_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(set && clr)) else $error("latch set and cleared together"); // R7

    AST_CLR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> !q_q) else $error("latch still set after clear"); // R7

endmodule

// File: rtl/beam_gate.sv
module beam_gate
    import beam_gate_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             burst_en,
    input  logic             shot_en,
    input  logic             req,
    input  logic [CNT_W-1:0] count,
    output logic             permit,
    output logic             done
);
    gate_regs_t r_d, r_q;

    logic cnt_load, cnt_dec, cnt_last;
    logic lat_set, lat_clr, lat_q;
    logic req_rise, mode_ok, seq_end;

    beam_gate_cnt #(.CNT_W(CNT_W)) i_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (cnt_load),
        .load_val (count),
        .dec      (cnt_dec),
        .last     (cnt_last)
    );

    beam_gate_latch i_latch (
        .clk   (clk),
        .rst_n (rst_n),
        .set   (lat_set),
        .clr   (lat_clr),
        .q     (lat_q)
    );

    always_comb begin
        r_d        = r_q;
        r_d.req_seen = req;
        req_rise   = req && !r_q.req_seen;
        mode_ok    = r_q.shot ? shot_en : burst_en;
        seq_end    = r_q.shot ? lat_q : cnt_last;
        cnt_load   = 1'b0;
        cnt_dec    = 1'b0;
        lat_set    = 1'b0;
        lat_clr    = 1'b0;

        case (r_q.state)
            ST_IDLE: begin
                r_d.permit = 1'b0;
                r_d.done   = 1'b0;
                if (req_rise && (shot_en || burst_en)) begin
                    r_d.shot = shot_en;
                    if (shot_en) begin
                        lat_set   = 1'b1;
                        r_d.state = ST_ARM;
                    end else begin
                        cnt_load = 1'b1;
                        if (count == '0) begin
                            r_d.state = ST_DONE;
                            r_d.done  = 1'b1;
                        end else begin
                            r_d.state = ST_ARM;
                        end
                    end
                end
            end
            ST_ARM: begin
                if (!req || !mode_ok) begin
                    r_d.state = ST_IDLE;
                    lat_clr   = r_q.shot;
                end else if (tick) begin
                    r_d.state  = ST_RUN;
                    r_d.permit = 1'b1;
                end
            end
            ST_RUN: begin
                if (!req || !mode_ok) begin
                    r_d.state  = ST_IDLE;
                    r_d.permit = 1'b0;
                    lat_clr    = r_q.shot;
                end else if (tick) begin
                    if (seq_end) begin
                        r_d.state  = ST_DONE;
                        r_d.permit = 1'b0;
                        r_d.done   = 1'b1;
                        lat_clr    = r_q.shot;
                    end else begin
                        cnt_dec = !r_q.shot;
                    end
                end
            end
            default: begin
                r_d.permit = 1'b0;
                if (!req) begin
                    r_d.state = ST_IDLE;
                    r_d.done  = 1'b0;
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= GATE_RESET;
        end else begin
            r_q <= r_d;
        end
    end

    assign permit = r_q.permit;
    assign done   = r_q.done;

    AST_PERMIT_ON_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(permit) |-> $past(tick)) else $error("permit rose without strobe"); // R9

    AST_DONE_NO_BEAM: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !permit) else $error("permit high while done"); // R4

    AST_DONE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (done && req) |=> done) else $error("done dropped while request held"); // R4

    AST_ABORT_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        (permit && !req) |=> !permit) else $error("permit held after request drop"); // R10

    AST_ABORT_MODE: assert property (@(posedge clk) disable iff (!rst_n)
        (permit && !mode_ok) |=> !permit) else $error("permit held after mode drop"); // R10

    AST_SHOT_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        (permit && r_q.shot && tick) |=> !permit) else $error("single shot kept permit"); // R7

    AST_NO_MODE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.state == ST_IDLE && !shot_en && !burst_en) |=> (!permit && !done))
        else $error("sequence started without a mode"); // R11

endmodule

// File: tb/test_beam_gate.sv
module test_beam_gate;
    localparam int CNT_W = 8;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             tick = 1'b0;
    logic             burst_en = 1'b0;
    logic             shot_en = 1'b0;
    logic             req = 1'b0;
    logic [CNT_W-1:0] count = '0;
    logic             permit, done;

    int total = 0;
    int bad = 0;

    always #10 clk = ~clk;

    beam_gate #(.CNT_W(CNT_W)) i_beam_gate (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick),
        .burst_en (burst_en),
        .shot_en  (shot_en),
        .req      (req),
        .count    (count),
        .permit   (permit),
        .done     (done)
    );

    task automatic check(input string tag, input logic exp_p, input logic exp_d);
        total++;
        if (permit !== exp_p || done !== exp_d) begin
            bad++;
            $display("FAIL %s: permit=%b done=%b expected permit=%b done=%b (t=%0t)",
                     tag, permit, done, exp_p, exp_d, $time);
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic strobe();
        @(negedge clk) tick = 1'b1;
        @(negedge clk) tick = 1'b0;
    endtask

    task automatic release_req(input string tag);
        @(negedge clk) req = 1'b0;
        @(negedge clk);
        check(tag, 1'b0, 1'b0);
        burst_en = 1'b0;
        shot_en  = 1'b0;
        idle(2);
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        idle(3);
        check("R1 in reset", 1'b0, 1'b0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 after reset", 1'b0, 1'b0);
    endtask

    task automatic t_burst(input int n);
        @(negedge clk) begin burst_en = 1'b1; count = CNT_W'(n); req = 1'b1; end
        @(negedge clk);
        check("R2 armed", 1'b0, 1'b0);
        idle(3);
        check("R2 leading no beam", 1'b0, 1'b0);
        for (int k = 1; k <= n; k++) begin
            strobe();
            check("R3 window open", 1'b1, 1'b0);
            idle(2);
            check("R9 stable between strobes", 1'b1, 1'b0);
        end
        strobe();
        check("R3 window closed", 1'b0, 1'b1);
        strobe();
        idle(2);
        check("R4 done held, no beam", 1'b0, 1'b1);
        release_req("R4 done clears");
    endtask

    task automatic t_zero();
        @(negedge clk) begin burst_en = 1'b1; count = '0; req = 1'b1; end
        @(negedge clk);
        check("R5 zero count done", 1'b0, 1'b1);
        strobe();
        check("R5 zero count no beam", 1'b0, 1'b1);
        release_req("R5 release");
    endtask

    task automatic t_count_change();
        @(negedge clk) begin burst_en = 1'b1; count = 8'd2; req = 1'b1; end
        idle(2);
        strobe();
        check("R6 open", 1'b1, 1'b0);
        count = 8'd7;
        strobe();
        check("R6 still open", 1'b1, 1'b0);
        strobe();
        check("R6 closed at captured count", 1'b0, 1'b1);
        release_req("R6 release");
    endtask

    task automatic t_shot(input logic with_burst, input string tag);
        @(negedge clk) begin
            shot_en = 1'b1; burst_en = with_burst; count = 8'd5; req = 1'b1;
        end
        idle(2);
        check(tag, 1'b0, 1'b0);
        strobe();
        check(tag, 1'b1, 1'b0);
        strobe();
        check(tag, 1'b0, 1'b1);
        strobe();
        check(tag, 1'b0, 1'b1);
        release_req(tag);
    endtask

    task automatic t_abort_mode();
        @(negedge clk) begin burst_en = 1'b1; count = 8'd5; req = 1'b1; end
        idle(2);
        strobe();
        check("R10 open before abort", 1'b1, 1'b0);
        burst_en = 1'b0;
        @(negedge clk);
        check("R10 mode drop closes", 1'b0, 1'b0);
        burst_en = 1'b1;
        strobe();
        idle(1);
        check("R10 no reopen without edge", 1'b0, 1'b0);
        release_req("R10 release");
    endtask

    task automatic t_abort_req();
        @(negedge clk) begin shot_en = 1'b1; req = 1'b1; end
        idle(2);
        strobe();
        check("R10 shot open", 1'b1, 1'b0);
        req = 1'b0;
        @(negedge clk);
        check("R10 request drop closes", 1'b0, 1'b0);
        strobe();
        check("R10 stays closed", 1'b0, 1'b0);
        shot_en = 1'b0;
        idle(2);
    endtask

    task automatic t_no_mode();
        @(negedge clk) begin count = 8'd3; req = 1'b1; end
        idle(2);
        strobe();
        strobe();
        check("R11 no mode ignored", 1'b0, 1'b0);
        @(negedge clk) req = 1'b0;
        idle(2);
    endtask

    initial begin
        fork
            begin
                t_reset();
                t_burst(1);
                t_burst(3);
                t_zero();
                t_count_change();
                t_shot(1'b0, "R7 single shot");
                t_shot(1'b1, "R8 shot priority");
                t_abort_mode();
                t_abort_req();
                t_no_mode();
                t_burst(2);
            end
            begin
                repeat (20000) @(posedge clk);
                total++;
                bad++;
                $display("FAIL watchdog: run did not finish, expected completion");
            end
        join_any
        disable fork;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule